// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

The block latches rising edges on its event inputs into 32-bit pending words, one word per source set. It turns those words into two CPU interrupt lines. A fixed table gives some sources a priority level from 1 to 15; these are the high group. The high group drives the high line, and an encoded vector reports the highest level that is both pending and enabled. Every source with level 0 is in the low group. The low group drives the low line through a per-bit enable word in each set.

Software works through a plain register bus with one cycle of read latency. For each source set there is a status word, a write-one-to-clear word and a low-group enable word. Set index 0 is reserved for a combined status word and a combined control word. The control word holds the level mask and a global enable. A source number n maps to set n/32 and bit n%32, so numbers 0 to 31 do not exist. Input `src_i` bit k carries source number 32+k.

Top module: `icu_top`

## Requirements
- R1: A pending bit is set on the clock edge that sees its source input high after it was low in the previous cycle. It stays set until cleared. A source held high does not set the bit again after a clear.
- R2: A write to a set's clear word (select 1) clears each pending bit where the written data has a 1 and leaves the other bits unchanged. If a new edge and a clear hit the same bit in one cycle, the bit ends up set.
- R3: The low line is high when the global enable is set and some low-group (level 0) source is pending with its enable bit at 1. A high-group source never drives the low line, whatever its enable bit holds.
- R4: The fixed level table, by source number, is: 120 and 121 at level 15, 126 at 14, 125 at 13, 80 to 83 at 9, 64 and 65 at 8, 50 at 4, 49 at 3, 59 at 2, and 96 and 103 at 1. Every other source is at level 0.
- R5: The vector is the highest level L that has a pending source and has bit L of the combined control word set. When no level qualifies, the vector is 0.
- R6: The high line is high exactly when the global enable is set and the vector is nonzero.
- R7: The global enable is bit 31 of the combined control word. While it is clear, both lines stay low, but pending bits still latch.
- R8: The bus address is {set, select}, with select in the low 2 bits: 0 = status, 1 = clear, 2 = enable. A read returns its value in the cycle after the read strobe. The combined status word (set 0, select 0) carries the vector in bits 3:0, the high line in bit 8 and the low line in bit 9. The combined control word (set 0, select 2) keeps only bits 15:1 and 31. A clear word or select 3 reads 0.
- R9: Writes to a status word are ignored. A clear write does not change any enable word. A clear write to set 0 has no effect.
- R10: After reset, every pending word, enable word and the combined control word is 0, and both lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | (NSET-1)*32 | Event inputs; bit k is source number 32+k |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | clog2(NSET)+2 | Word address {set, select} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_hi_o | output | 1 | High-priority interrupt line |
| irq_lo_o | output | 1 | Low-priority interrupt line |

## Verification
The bench builds the block with the default NSET = 4. That gives three source sets, enough for every entry of the level table to exist. Levels that share a number, levels spread across different sets, and the top levels 13 to 15 therefore all compete for the vector. Directed steps cover masking the top level so the vector falls to a lower one, an edge colliding with a clear, and status writes being ignored. Random edges, clears and mask writes then check both lines and every register against a reference model.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int WORD  = 32;
  localparam int LVLS  = 16;
  localparam int LVL_W = 4;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int HI_FLAG = 8;
  localparam int LO_FLAG = 9;
  localparam int GEN_BIT = 31;
  localparam logic [WORD-1:0] CTRL_KEEP = 32'h8000_FFFE;

  // Fixed level of each source; 0 means low group.
  function automatic logic [LVL_W-1:0] level_of(int set, int bidx);
    logic [LVL_W-1:0] lv;
    lv = '0;
    case (set)
      1: case (bidx)
           17: lv = 4'd3;
           18: lv = 4'd4;
           27: lv = 4'd2;
           default: lv = '0;
         endcase
      2: case (bidx)
           0, 1: lv = 4'd8;
           16, 17, 18, 19: lv = 4'd9;
           default: lv = '0;
         endcase
      3: case (bidx)
           0, 7: lv = 4'd1;
           24, 25: lv = 4'd15;
           29: lv = 4'd13;
           30: lv = 4'd14;
           default: lv = '0;
         endcase
      default: lv = '0;
    endcase
    return lv;
  endfunction
endpackage

// File: rtl/icu_src_set.sv
module icu_src_set
  import icu_pkg::*;
#(
  parameter int SET = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WORD-1:0] src_i,
  input  logic            clr_we,
  input  logic            en_we,
  input  logic [WORD-1:0] wdata,
  output logic [WORD-1:0] pend_o,
  output logic [WORD-1:0] en_o,
  output logic            low_hit_o,
  output logic [LVLS-1:0] lvl_pend_o
);
  logic [WORD-1:0] src_q, pend_q, en_q, rise, clr_mask, is_hi;
  logic [LVLS-1:0] lvl_all;

  for (genvar b = 0; b < WORD; b++) begin : g_bit
    localparam logic [LVL_W-1:0] LV = level_of(SET, b);
    assign is_hi[b] = (LV != '0);
  end

  assign rise     = src_i & ~src_q;
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_mask) | rise;
      if (en_we) en_q <= wdata;
    end
  end

  always_comb begin
    lvl_all = '0;
    for (int b = 0; b < WORD; b++)
      lvl_all[level_of(SET, b)] = lvl_all[level_of(SET, b)] | pend_q[b];
  end

  assign lvl_pend_o = {lvl_all[LVLS-1:1], 1'b0};
  assign low_hit_o  = |(pend_q & en_q & ~is_hi);
  assign pend_o     = pend_q;
  assign en_o       = en_q;

  assert_edge_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_q & $past(wdata & ~rise)) == '0));
  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc
  import icu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVLS-1:0]  req_i,
  output logic [LVL_W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int l = 1; l < LVLS; l++)
      if (req_i[l]) vec_o = LVL_W'(l);
  end

  assert_vec_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o != '0) |-> req_i[vec_o]);
  assert_vec_highest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i >> vec_o) <= 16'd1));
  assert_vec_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[LVLS-1:1] == '0) |-> (vec_o == '0));
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int NSET = 4,
  localparam int SET_W = $clog2(NSET),
  localparam int AW    = SET_W + 2,
  localparam int SRC_W = (NSET - 1) * WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WORD-1:0]  bus_wdata,
  output logic [WORD-1:0]  bus_rdata,
  output logic             irq_hi_o,
  output logic             irq_lo_o
);
  logic [SET_W-1:0] a_set;
  reg_sel_e         a_sel;
  logic [WORD-1:0]  pend_a [NSET];
  logic [WORD-1:0]  en_a   [NSET];
  logic [LVLS-1:0]  lvl_a  [NSET];
  logic [NSET-1:0]  low_a;
  logic [WORD-1:0]  ctrl_q, cstat, rd_d;
  logic [LVLS-1:0]  lvl_any, req;
  logic [LVL_W-1:0] vec;
  logic             gen;

  assign a_set = bus_addr[AW-1:2];
  assign a_sel = reg_sel_e'(bus_addr[1:0]);

  assign pend_a[0] = '0;
  assign en_a[0]   = '0;
  assign lvl_a[0]  = '0;
  assign low_a[0]  = 1'b0;

  for (genvar s = 1; s < NSET; s++) begin : g_set
    logic hit;
    assign hit = (a_set == SET_W'(s));
    icu_src_set #(.SET(s)) i_set (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i[(s-1)*WORD +: WORD]),
      .clr_we     (bus_wr && hit && a_sel == SEL_CLR),
      .en_we      (bus_wr && hit && a_sel == SEL_EN),
      .wdata      (bus_wdata),
      .pend_o     (pend_a[s]),
      .en_o       (en_a[s]),
      .low_hit_o  (low_a[s]),
      .lvl_pend_o (lvl_a[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_wr && a_set == '0 && a_sel == SEL_EN)
      ctrl_q <= bus_wdata & CTRL_KEEP;
  end

  always_comb begin
    lvl_any = '0;
    for (int s = 0; s < NSET; s++) lvl_any = lvl_any | lvl_a[s];
  end

  assign req = lvl_any & ctrl_q[LVLS-1:0];

  icu_prio_enc i_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req),
    .vec_o (vec)
  );

  assign gen      = ctrl_q[GEN_BIT];
  assign irq_hi_o = gen && (vec != '0);
  assign irq_lo_o = gen && (|low_a);

  always_comb begin
    cstat = '0;
    cstat[LVL_W-1:0] = vec;
    cstat[HI_FLAG]   = irq_hi_o;
    cstat[LO_FLAG]   = irq_lo_o;
  end

  always_comb begin
    rd_d = '0;
    if (a_set == '0) begin
      if (a_sel == SEL_STAT)    rd_d = cstat;
      else if (a_sel == SEL_EN) rd_d = ctrl_q;
    end else if (int'(a_set) < NSET) begin
      if (a_sel == SEL_STAT)    rd_d = pend_a[a_set];
      else if (a_sel == SEL_EN) rd_d = en_a[a_set];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  assert_gen_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[GEN_BIT] |-> (!irq_hi_o && !irq_lo_o));
  assert_hi_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi_o |-> (vec != '0));
  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(4)) |=> (bus_rdata == $past(pend_a[1])));
endmodule

// File: tb/test_icu_top.sv
`timescale 1ns/1ps
module test_icu_top;
  localparam int NSET = 4;
  localparam int AW = 4;
  localparam int SW = (NSET - 1) * 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SW-1:0] src = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_hi_o, irq_lo_o;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  icu_top #(.NSET(NSET)) i_icu_top (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o));

  // reference model
  logic [31:0] pm [NSET];
  logic [31:0] em [NSET];
  logic [31:0] cm;
  logic [SW-1:0] sq;

  function automatic int prio_ref(int n);
    case (n)
      120, 121: return 15;
      126: return 14;
      125: return 13;
      80, 81, 82, 83: return 9;
      64, 65: return 8;
      50: return 4;
      49: return 3;
      59: return 2;
      96, 103: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_vec();
    int best = 0;
    for (int n = 32; n < NSET*32; n++) begin
      int lv = prio_ref(n);
      if (lv != 0 && pm[n/32][n%32] && cm[lv] && lv > best) best = lv;
    end
    return best;
  endfunction

  function automatic logic exp_lo();
    logic any = 1'b0;
    for (int n = 32; n < NSET*32; n++)
      if (prio_ref(n) == 0 && pm[n/32][n%32] && em[n/32][n%32]) any = 1'b1;
    return cm[31] & any;
  endfunction

  function automatic logic exp_hi();
    return cm[31] && (exp_vec() != 0);
  endfunction

  function automatic logic [31:0] read_ref(logic [AW-1:0] a);
    int s = int'(a[3:2]);
    logic [31:0] r = '0;
    if (s == 0) begin
      if (a[1:0] == 2'd0) begin
        r[3:0] = 4'(exp_vec());
        r[8] = exp_hi();
        r[9] = exp_lo();
      end else if (a[1:0] == 2'd2) r = cm;
    end else begin
      if (a[1:0] == 2'd0) r = pm[s];
      else if (a[1:0] == 2'd2) r = em[s];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model follows the inputs seen at the edge
  task automatic cyc();
    @(posedge clk);
    if (!rst_n) begin
      for (int s = 0; s < NSET; s++) begin pm[s] = '0; em[s] = '0; end
      cm = '0; sq = '0;
    end else begin
      for (int s = 1; s < NSET; s++) begin
        logic [31:0] clr, rise;
        clr = (bus_wr && bus_addr == AW'(s*4+1)) ? bus_wdata : '0;
        rise = src[(s-1)*32 +: 32] & ~sq[(s-1)*32 +: 32];
        pm[s] = (pm[s] & ~clr) | rise;
        if (bus_wr && bus_addr == AW'(s*4+2)) em[s] = bus_wdata;
      end
      if (bus_wr && bus_addr == AW'(2)) cm = bus_wdata & 32'h8000FFFE;
      sq = src;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    logic [31:0] e;
    bus_rd = 1'b1; bus_addr = a;
    e = read_ref(a);
    cyc();
    chk(tag, bus_rdata, e);
  endtask

  task automatic lines(string tag);
    chk({tag, " hi"}, 32'(irq_hi_o), 32'(exp_hi()));
    chk({tag, " lo"}, 32'(irq_lo_o), 32'(exp_lo()));
  endtask

  task automatic pulse(int n);
    src[n-32] = 1'b1; cyc();
    src[n-32] = 1'b0; cyc();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 hi", 32'(irq_hi_o), 0);
    chk("R10 lo", 32'(irq_lo_o), 0);
    rd(4'h0, "R10 cstat");
    rd(4'h4, "R10 pend1");
    rd(4'h2, "R10 ctrl");
    // R4 R5 R6 top level
    wr(4'h2, 32'hFFFF_FFFF);
    rd(4'h2, "R8 ctrl keep");
    pulse(121);
    bus_rd = 1'b1; bus_addr = 4'h0; cyc();
    chk("R5 vec 15", bus_rdata, 32'h10F);
    chk("R6 hi", 32'(irq_hi_o), 1);
    // R5 mask level 15 -> level 3 wins
    wr(4'h2, 32'h8000_7FFE);
    pulse(49);
    bus_rd = 1'b1; bus_addr = 4'h0; cyc();
    chk("R5 vec 3", bus_rdata, 32'h103);
    pulse(126);
    rd(4'h0, "R4 level 14");
    // R7 global off, pending still latches
    wr(4'h2, 32'h0000_FFFE);
    pulse(50);
    chk("R7 hi off", 32'(irq_hi_o), 0);
    rd(4'h4, "R7 pend latched");
    // R2 edge and clear same cycle
    src[121-32] = 1'b1; bus_wr = 1'b1; bus_addr = 4'hD; bus_wdata = 32'h0200_0000; cyc();
    rd(4'hC, "R2 edge wins");
    wr(4'hD, 32'h0200_0000);
    rd(4'hC, "R2 cleared");
    cyc(); cyc();
    rd(4'hC, "R1 held high no reset");
    src[121-32] = 1'b0;
    // R9 status write ignored, clear leaves enable
    wr(4'h6, 32'hA5A5_0F0F);
    wr(4'h4, 32'h0);
    rd(4'h4, "R9 status write ignored");
    wr(4'h5, 32'h0000_0001);
    rd(4'h6, "R9 enable kept");
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h2, "R9 set0 clear");
    rd(4'h7, "R8 unmapped");
    rd(4'h5, "R8 clear reads 0");
    // R3 high source never on low line
    wr(4'h2, 32'h8000_0000);
    wr(4'h6, 32'hFFFF_FFFF);
    wr(4'h5, 32'hFFFF_FFFF);
    pulse(49);
    chk("R3 high src no lo", 32'(irq_lo_o), 0);
    pulse(37);
    chk("R3 low src lo", 32'(irq_lo_o), 1);
    lines("R3 model");
    // random phase
    for (int it = 0; it < 4000; it++) begin
      int k;
      src = src ^ (SW'({$urandom, $urandom, $urandom}) & SW'({$urandom, $urandom, $urandom})
                   & SW'({$urandom, $urandom, $urandom}));
      k = $urandom_range(0, 9);
      if (k < 3) begin
        bus_wr = 1'b1;
        bus_addr = AW'($urandom_range(1, 3) * 4 + 1);
        bus_wdata = $urandom;
      end else if (k == 3) begin
        bus_wr = 1'b1;
        bus_addr = AW'($urandom_range(0, 3) * 4 + $urandom_range(0, 3));
        bus_wdata = $urandom | (($urandom_range(0, 3) != 0) ? 32'h8000_0000 : 32'h0);
      end
      if (it % 5 == 0) begin
        logic [31:0] e;
        bus_rd = 1'b1;
        if (!bus_wr) bus_addr = AW'($urandom);
        e = read_ref(bus_addr);
        cyc();
        chk("R8 random read", bus_rdata, e);
      end else cyc();
      lines("R5 R6 R3 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule